// File: doc/BRIEF.md
# Legacy Interrupt Message Generator

This block turns level-sensitive, active-low legacy interrupt lines into a stream of assert and de-assert message requests for an upstream posted-request buffer. Each line is brought into the clock domain through a short synchronizer. A falling level records a pending assert event for that line and a rising level records a pending de-assert event. Each event stays pending until the buffer takes the matching message. Messages are never queued: a line holds at most one pending assert and one pending de-assert, so a burst of toggles folds into a single pair.

A round-robin arbiter picks the next line with pending work. A message is only launched while the target side of the local bus is not carrying a posted transaction. Once launched, the message is held with stable fields until the buffer accepts it. While it is held, a retry indication tells the target side to turn away new posted writes. Line A produces messages with index 0, and so on up to line D with index 3; there is no remapping. Every message carries a requester ID taken from a configuration input.

Top module: `intx_msg_gen`

## Requirements
- R1: After reset, `msg_valid_o` and `post_retry_o` are low, no event is pending, and the round-robin search starts at line A (index 0).
- R2: A high-to-low change on line i (A=0 … D=3) raises `msg_valid_o` on the fourth rising clock edge after the change, with `msg_pin_o` = i and `msg_assert_o` = 1, provided `tgt_posted_busy_i` is low and nothing else is pending.
- R3: A low-to-high change on line i produces a message with `msg_pin_o` = i and `msg_assert_o` = 0.
- R4: A launched message keeps `msg_valid_o` high with unchanged `msg_pin_o`, `msg_assert_o` and `msg_rid_o` until a cycle with `buf_ready_i` high, and `msg_valid_o` is low in the cycle after that acceptance. The pending event is cleared only by that acceptance.
- R5: No message is launched while `tgt_posted_busy_i` is high. Pending events wait, and a message is launched on the first rising edge at which busy is sampled low.
- R6: `post_retry_o` is high exactly while a message is held (`msg_valid_o` high).
- R7: When a line has both an assert and a de-assert pending, the assert message is sent first. A de-assert for a line is never launched while an assert for that line is pending.
- R8: The arbiter serves lines in round-robin order. The search starts at the line after the one whose message was last accepted and wraps from D to A.
- R9: Any number of toggles of a line while messages are blocked results in exactly one assert message followed by one de-assert message, and then no further message.
- R10: `msg_rid_o` equals the value of `req_id_i` at the moment the message is launched, and it does not follow later changes of `req_id_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_n_i | input | NUM_PINS (4) | Active-low legacy interrupt lines, bit 0 = line A |
| tgt_posted_busy_i | input | 1 | Target side is carrying a posted transaction |
| req_id_i | input | RID_W (16) | Requester ID placed in every message |
| buf_ready_i | input | 1 | Upstream posted buffer accepts the held message this cycle |
| msg_valid_o | output | 1 | A message is held and offered to the buffer |
| msg_pin_o | output | PIN_W (2) | Line index of the held message |
| msg_assert_o | output | 1 | 1 = assert message, 0 = de-assert message |
| msg_rid_o | output | RID_W (16) | Requester ID of the held message |
| post_retry_o | output | 1 | Retry incoming posted transactions while a message is held |

## Verification
The main function is driven with one line falling on its own, which fixes the exact edge latency and the index mapping. The same line then rises, which separates the assert kind from the de-assert kind. All four lines are then changed together while busy holds launching off, so the order in which they drain shows whether the pointer really moves past the last served line rather than restarting at A. A single line pulsed once and a line toggled three times, both under busy, tell correct assert-before-de-assert ordering and toggle folding apart from a design that queues or reorders events. A held message with the buffer not ready and the requester ID changing separates latched fields from fields that pass straight through.

// File: rtl/intx_msg_pkg.sv
package intx_msg_pkg;
   typedef enum logic {
      KIND_DEASSERT = 1'b0,
      KIND_ASSERT   = 1'b1
   } msg_kind_e;

   localparam int unsigned DEF_NUM_PINS    = 4;
   localparam int unsigned DEF_RID_W       = 16;
   localparam int unsigned DEF_SYNC_STAGES = 2;
endpackage

// File: rtl/intx_pin_tracker.sv
module intx_pin_tracker #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_n_i,
   input  logic clr_a_i,
   input  logic clr_d_i,
   output logic pend_a_o,
   output logic pend_d_o
);
   logic level_n;
   logic prev_n;
   logic fell;
   logic rose;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign level_n = pin_n_i;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain <= '1;
            end else if (SYNC_STAGES == 1) begin
               chain <= pin_n_i;
            end else begin
               chain <= {chain[SYNC_STAGES-2:0], pin_n_i};
            end
         end
         assign level_n = chain[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_n <= 1'b1;
      end else begin
         prev_n <= level_n;
      end
   end

   assign fell = prev_n & ~level_n;
   assign rose = ~prev_n & level_n;

   // a new edge wins over a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_a_o <= 1'b0;
         pend_d_o <= 1'b0;
      end else begin
         if (fell) begin
            pend_a_o <= 1'b1;
         end else if (clr_a_i) begin
            pend_a_o <= 1'b0;
         end
         if (rose) begin
            pend_d_o <= 1'b1;
         end else if (clr_d_i) begin
            pend_d_o <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/intx_rr_arb.sv
module intx_rr_arb #(
   parameter int unsigned NUM_REQ = 4,
   parameter int unsigned IDX_W   = 2
) (
   input  logic [NUM_REQ-1:0] req_i,
   input  logic [IDX_W-1:0]   ptr_i,
   output logic               any_o,
   output logic [IDX_W-1:0]   gnt_idx_o
);
   always_comb begin
      int idx;
      any_o     = 1'b0;
      gnt_idx_o = '0;
      for (int k = 0; k < int'(NUM_REQ); k++) begin
         idx = int'(ptr_i) + k;
         if (idx >= int'(NUM_REQ)) begin
            idx = idx - int'(NUM_REQ);
         end
         if (!any_o && req_i[idx]) begin
            any_o     = 1'b1;
            gnt_idx_o = IDX_W'(idx);
         end
      end
   end
endmodule

// File: rtl/intx_msg_gen.sv
module intx_msg_gen
   import intx_msg_pkg::*;
#(
   parameter int unsigned NUM_PINS    = DEF_NUM_PINS,
   parameter int unsigned RID_W       = DEF_RID_W,
   parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES,
   localparam int unsigned PIN_W      = (NUM_PINS < 2) ? 1 : $clog2(NUM_PINS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pin_n_i,
   input  logic                tgt_posted_busy_i,
   input  logic [RID_W-1:0]    req_id_i,
   input  logic                buf_ready_i,
   output logic                msg_valid_o,
   output logic [PIN_W-1:0]    msg_pin_o,
   output logic                msg_assert_o,
   output logic [RID_W-1:0]    msg_rid_o,
   output logic                post_retry_o
);
   generate
      if (NUM_PINS < 2) begin : g_bad_pins
         $error("intx_msg_gen: NUM_PINS must be at least 2");
      end
      if (RID_W < 1) begin : g_bad_rid
         $error("intx_msg_gen: RID_W must be at least 1");
      end
      if (SYNC_STAGES > 4) begin : g_bad_sync
         $error("intx_msg_gen: SYNC_STAGES must be 0 to 4");
      end
   endgenerate

   logic [NUM_PINS-1:0] pend_a;
   logic [NUM_PINS-1:0] pend_d;
   logic [NUM_PINS-1:0] clr_a;
   logic [NUM_PINS-1:0] clr_d;
   logic [NUM_PINS-1:0] pend_any;

   logic                hold_vld;
   logic [PIN_W-1:0]    hold_pin;
   msg_kind_e           hold_kind;
   logic [RID_W-1:0]    hold_rid;
   logic [PIN_W-1:0]    rr_ptr;

   logic                arb_any;
   logic [PIN_W-1:0]    arb_idx;
   logic                accept;
   logic                launch;

   assign accept   = hold_vld & buf_ready_i;
   assign pend_any = pend_a | pend_d;
   assign launch   = ~hold_vld & ~tgt_posted_busy_i & arb_any;

   generate
      for (genvar p = 0; p < int'(NUM_PINS); p++) begin : g_pin
         assign clr_a[p] = accept && (hold_pin == PIN_W'(p)) && (hold_kind == KIND_ASSERT);
         assign clr_d[p] = accept && (hold_pin == PIN_W'(p)) && (hold_kind == KIND_DEASSERT);

         intx_pin_tracker #(
            .SYNC_STAGES(SYNC_STAGES)
         ) trk_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin_n_i (pin_n_i[p]),
            .clr_a_i (clr_a[p]),
            .clr_d_i (clr_d[p]),
            .pend_a_o(pend_a[p]),
            .pend_d_o(pend_d[p])
         );
      end
   endgenerate

   intx_rr_arb #(
      .NUM_REQ(NUM_PINS),
      .IDX_W  (PIN_W)
   ) arb_i (
      .req_i    (pend_any),
      .ptr_i    (rr_ptr),
      .any_o    (arb_any),
      .gnt_idx_o(arb_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_vld  <= 1'b0;
         hold_pin  <= '0;
         hold_kind <= KIND_DEASSERT;
         hold_rid  <= '0;
      end else if (accept) begin
         hold_vld <= 1'b0;
      end else if (launch) begin
         hold_vld  <= 1'b1;
         hold_pin  <= arb_idx;
         hold_kind <= pend_a[arb_idx] ? KIND_ASSERT : KIND_DEASSERT;
         hold_rid  <= req_id_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rr_ptr <= '0;
      end else if (accept) begin
         if (hold_pin == PIN_W'(NUM_PINS - 1)) begin
            rr_ptr <= '0;
         end else begin
            rr_ptr <= hold_pin + 1'b1;
         end
      end
   end

   assign msg_valid_o  = hold_vld;
   assign msg_pin_o    = hold_pin;
   assign msg_assert_o = (hold_kind == KIND_ASSERT);
   assign msg_rid_o    = hold_rid;
   assign post_retry_o = hold_vld;
endmodule

// File: rtl/intx_msg_gen_chk.sv
module intx_msg_gen_chk #(
   parameter int unsigned NUM_PINS = 4,
   parameter int unsigned PIN_W    = 2,
   parameter int unsigned RID_W    = 16
) (
   input logic                clk,
   input logic                rst_n,
   input logic                tgt_posted_busy_i,
   input logic                buf_ready_i,
   input logic                msg_valid_o,
   input logic [PIN_W-1:0]    msg_pin_o,
   input logic                msg_assert_o,
   input logic [RID_W-1:0]    msg_rid_o,
   input logic                post_retry_o,
   input logic [NUM_PINS-1:0] pend_a
);
   // R5
   launch_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(msg_valid_o) |-> !$past(tgt_posted_busy_i));

   // R4
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid_o && !buf_ready_i) |=>
         (msg_valid_o && $stable(msg_pin_o) && $stable(msg_assert_o) && $stable(msg_rid_o)));

   // R4
   drop_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid_o && buf_ready_i) |=> !msg_valid_o);

   // R7
   deassert_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(msg_valid_o) && !msg_assert_o) |-> !$past(pend_a[msg_pin_o]));

   // R6
   retry_when_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(msg_valid_o) |-> post_retry_o);
endmodule

bind intx_msg_gen intx_msg_gen_chk #(
   .NUM_PINS(NUM_PINS),
   .PIN_W   (PIN_W),
   .RID_W   (RID_W)
) chk_i (
   .clk              (clk),
   .rst_n            (rst_n),
   .tgt_posted_busy_i(tgt_posted_busy_i),
   .buf_ready_i      (buf_ready_i),
   .msg_valid_o      (msg_valid_o),
   .msg_pin_o        (msg_pin_o),
   .msg_assert_o     (msg_assert_o),
   .msg_rid_o        (msg_rid_o),
   .post_retry_o     (post_retry_o),
   .pend_a           (pend_a)
);

// File: tb/intx_msg_gen_tb_top.sv
`timescale 1ns/1ps
module intx_msg_gen_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  pin_n = 4'hF;
   logic        busy = 1'b0;
   logic [15:0] rid = 16'h1234;
   logic        ready = 1'b0;
   logic        valid;
   logic [1:0]  mpin;
   logic        mass;
   logic [15:0] mrid;
   logic        retry;

   int tests = 0;
   int fails = 0;
   int exp_ptr = 0;

   always #5 clk = ~clk;

   intx_msg_gen dut_i (
      .clk              (clk),
      .rst_n            (rst_n),
      .pin_n_i          (pin_n),
      .tgt_posted_busy_i(busy),
      .req_id_i         (rid),
      .buf_ready_i      (ready),
      .msg_valid_o      (valid),
      .msg_pin_o        (mpin),
      .msg_assert_o     (mass),
      .msg_rid_o        (mrid),
      .post_retry_o     (retry)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // waits for a message, checks it, accepts it, checks valid drops
   task automatic take(input int epin, input int eass, input string req);
      int n = 0;
      while (!valid && n < 60) begin
         @(negedge clk);
         n++;
      end
      chk(valid, {req, " valid"}, int'(valid), 1);
      chk(int'(mpin) == epin, {req, " pin"}, int'(mpin), epin);
      chk(int'(mass) == eass, {req, " kind"}, int'(mass), eass);
      chk(retry == valid, "R6 retry", int'(retry), int'(valid));
      ready = 1'b1;
      @(negedge clk);
      ready = 1'b0;
      chk(!valid, "R4 drop after accept", int'(valid), 0);
      exp_ptr = (int'(mpin) + 1) % 4;
   endtask

   task automatic quiet(input int cyc, input string req);
      bit seen = 1'b0;
      repeat (cyc) begin
         @(negedge clk);
         if (valid) seen = 1'b1;
      end
      chk(!seen, req, int'(seen), 0);
   endtask

   task automatic t_reset();
      chk(!valid, "R1 valid after reset", int'(valid), 0);
      chk(!retry, "R1 retry after reset", int'(retry), 0);
      quiet(8, "R1 nothing pending");
   endtask

   task automatic t_single();
      pin_n[0] = 1'b0;
      repeat (3) @(negedge clk);
      chk(!valid, "R2 not before fourth edge", int'(valid), 0);
      @(negedge clk);
      chk(valid, "R2 valid at fourth edge", int'(valid), 1);
      chk(mrid == rid, "R10 rid", int'(mrid), int'(rid));
      take(0, 1, "R2 line A assert");
      pin_n[0] = 1'b1;
      take(0, 0, "R3 line A deassert");
   endtask

   task automatic t_stall();
      busy = 1'b1;
      pin_n[1] = 1'b0;
      quiet(12, "R5 no launch while busy");
      busy = 1'b0;
      @(negedge clk);
      chk(valid, "R5 launch once busy low", int'(valid), 1);
      take(1, 1, "R5 line B assert");
      pin_n[1] = 1'b1;
      take(1, 0, "R3 line B deassert");
   endtask

   task automatic t_hold();
      logic [15:0] first;
      pin_n[2] = 1'b0;
      while (!valid) @(negedge clk);
      first = mrid;
      chk(first == rid, "R10 rid at launch", int'(first), int'(rid));
      rid = 16'hBEEF;
      repeat (6) begin
         @(negedge clk);
         chk(valid && mpin == 2'd2 && mass, "R4 held fields", {mpin, mass}, 5);
         chk(mrid == first, "R10 rid frozen", int'(mrid), int'(first));
         chk(retry, "R6 retry while held", int'(retry), 1);
      end
      take(2, 1, "R4 line C assert");
      pin_n[2] = 1'b1;
      while (!valid) @(negedge clk);
      chk(mrid == 16'hBEEF, "R10 new rid", int'(mrid), 16'hBEEF);
      take(2, 0, "R3 line C deassert");
   endtask

   task automatic t_rr();
      int start;
      busy = 1'b1;
      pin_n = 4'h0;
      repeat (6) @(negedge clk);
      busy = 1'b0;
      start = exp_ptr;
      for (int k = 0; k < 4; k++) take((start + k) % 4, 1, "R8 rr assert order");
      busy = 1'b1;
      pin_n = 4'hF;
      repeat (6) @(negedge clk);
      busy = 1'b0;
      start = exp_ptr;
      for (int k = 0; k < 4; k++) take((start + k) % 4, 0, "R8 rr deassert order");
      quiet(10, "R8 drained");
   endtask

   task automatic t_both();
      busy = 1'b1;
      pin_n[2] = 1'b0;
      repeat (4) @(negedge clk);
      pin_n[2] = 1'b1;
      repeat (6) @(negedge clk);
      busy = 1'b0;
      take(2, 1, "R7 assert first");
      take(2, 0, "R7 deassert second");
      quiet(10, "R7 no extra");
   endtask

   task automatic t_fold();
      busy = 1'b1;
      for (int k = 0; k < 3; k++) begin
         pin_n[3] = 1'b0;
         repeat (4) @(negedge clk);
         pin_n[3] = 1'b1;
         repeat (4) @(negedge clk);
      end
      repeat (4) @(negedge clk);
      busy = 1'b0;
      take(3, 1, "R9 folded assert");
      take(3, 0, "R9 folded deassert");
      quiet(20, "R9 no duplicates");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_single();
      t_stall();
      t_hold();
      t_rr();
      t_both();
      t_fold();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule